// File: doc/BRIEF.md
# Palette Colour Expansion Lookup

This block converts a 14-bit pixel colour index into a 24-bit RGB value. The index first passes through an indirection step. Its four top bits and four bottom bits together address a 256-entry table of 4-bit values. The table value replaces the bottom nibble of the index. The six middle bits pass through unchanged, and the result is a 10-bit palette word number. The block then reads that word from a byte-wide palette RAM, which a CPU writes one byte at a time. Each 16-bit word is held across an even/odd byte pair, with the more significant byte at the even address. The three 5-bit colour fields of the word are then widened to 8 bits by replicating their top bits.

A pixel enters with a valid strobe and leaves three cycles later with its own valid strobe. Back-to-back pixels are accepted every cycle. The 4-bit table is filled through its own load port before pixels that depend on it are presented. CPU writes to the palette may arrive at any time. A write that lands in the same cycle as the palette read of an in-flight pixel does not affect that pixel.

Top module: `palette_expand`

## Requirements
- R1: Each cycle with `pixValid` high produces exactly one cycle with `rgbValid` high, three clock edges later, and results leave in the order the pixels entered.
- R2: The palette word number for index `i` is `{i[9:4], T[{i[13:10], i[3:0]}]}`, where `T` is the 4-bit translation table.
- R3: Palette word `n` takes bits 15:8 from palette byte address `2n` and bits 7:0 from byte address `2n+1`.
- R4: Within a palette word, red is bits 4:0, green is bits 9:5 and blue is bits 14:10. Bit 15 has no effect on the output.
- R5: Each 5-bit channel `c` becomes the 8-bit value `{c, c[4:2]}`. The output is packed as `rgb = {red, green, blue}`, with red in bits 23:16 and blue in bits 7:0.
- R6: A table load (`promWe` with `promAddr`, `promData`) takes effect for every pixel presented in a later cycle.
- R7: A palette byte write presented in the same cycle as a pixel is seen by that pixel. A write presented in the cycle after the pixel returns the old data to that pixel.
- R8: During reset and after it, until a pixel arrives, `rgbValid` is low and `rgb` is zero.
- R9: While `rgbValid` is low, `rgb` keeps the last value delivered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pixValid | input | 1 | Pixel index valid |
| pixIdx | input | 14 | Pixel colour index |
| cpuWe | input | 1 | Palette byte write enable |
| cpuAddr | input | 11 | Palette byte address |
| cpuData | input | 8 | Palette byte write data |
| promWe | input | 1 | Translation table load enable |
| promAddr | input | 8 | Translation table entry address |
| promData | input | 4 | Translation table entry value |
| rgbValid | output | 1 | Output colour valid |
| rgb | output | 24 | Expanded colour, red in the top byte |

## Verification
The bench fills the table and palette with random contents and streams random indices through the block, first back to back and then with random gaps. These streams separate correct index-bit placement and table addressing from errors in latency or ordering. Hand-chosen words with saturated channels, empty channels and only bit 15 toggled isolate the field positions, the byte order and the bit replication. Table rewrites placed just before a pixel test load visibility. A palette write placed in the same cycle as a pixel, and another in the cycle after it, distinguish the write-first and read-old cases.

// File: rtl/palexp_pkg.sv
package palexp_pkg;

  // Strobes from control to datapath
  typedef struct packed {
    logic loadIdx;   // capture translated word number
    logic loadWord;  // capture palette word
    logic loadRgb;   // capture expanded colour
    logic wrHi;      // palette write, upper byte of word
    logic wrLo;      // palette write, lower byte of word
    logic promWr;    // translation table load
  } palStrobe_t;

endpackage

// File: rtl/palexp_ctrl.sv
module palexp_ctrl
  import palexp_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       pixValid,
  input  logic       cpuWe,
  input  logic       cpuByteSel,
  input  logic       promWe,
  output palStrobe_t strobe,
  output logic       rgbValid
);

  logic idxValid;
  logic wordValid;

  always_ff @(posedge clk) begin
    if (rst) begin
      idxValid  <= 1'b0;
      wordValid <= 1'b0;
      rgbValid  <= 1'b0;
    end else begin
      idxValid  <= pixValid;
      wordValid <= idxValid;
      rgbValid  <= wordValid;
    end
  end

  always_comb begin
    strobe.loadIdx  = pixValid;
    strobe.loadWord = idxValid;
    strobe.loadRgb  = wordValid;
    strobe.wrHi     = cpuWe & ~cpuByteSel;
    strobe.wrLo     = cpuWe & cpuByteSel;
    strobe.promWr   = promWe;
  end

  // R1
  pixel_latency_chk: assert property (@(posedge clk) disable iff (rst)
    pixValid |-> ##3 rgbValid);

  // R8
  reset_quiet_chk: assert property (@(posedge clk)
    rst |=> !rgbValid);

endmodule

// File: rtl/palexp_datapath.sv
module palexp_datapath
  import palexp_pkg::*;
#(
  parameter int IDX_W   = 14,
  parameter int PAGE_W  = 4,
  parameter int LOW_W   = 4,
  parameter int WORD_AW = 10,
  parameter int CH_W    = 5,
  parameter int OUT_W   = 8
) (
  input  logic                   clk,
  input  logic                   rst,
  input  palStrobe_t             strobe,
  input  logic [IDX_W-1:0]       pixIdx,
  input  logic [WORD_AW-1:0]     wordAddr,
  input  logic [7:0]             cpuData,
  input  logic [PAGE_W+LOW_W-1:0] promAddr,
  input  logic [LOW_W-1:0]       promData,
  output logic [3*OUT_W-1:0]     rgb
);

  localparam int PROM_AW    = PAGE_W + LOW_W;
  localparam int PROM_DEPTH = 1 << PROM_AW;
  localparam int MID_W      = WORD_AW - LOW_W;
  localparam int WORD_DEPTH = 1 << WORD_AW;
  localparam int USED_W     = 3 * CH_W;
  localparam int HI_W       = USED_W - 8;
  localparam int REP_W      = OUT_W - CH_W;

  // Translation table
  logic [LOW_W-1:0] promMem [PROM_DEPTH];

  always_ff @(posedge clk) begin
    if (strobe.promWr) promMem[promAddr] <= promData;
  end

  // Stage 1: index translation
  logic [WORD_AW-1:0] wordIdx;
  logic [PROM_AW-1:0] promSel;

  assign promSel = {pixIdx[IDX_W-1 -: PAGE_W], pixIdx[LOW_W-1:0]};

  always_ff @(posedge clk) begin
    if (rst)                 wordIdx <= '0;
    else if (strobe.loadIdx) wordIdx <= {pixIdx[LOW_W +: MID_W], promMem[promSel]};
  end

  // Palette storage; the unused top bit of each word is never kept
  logic [HI_W-1:0] hiMem [WORD_DEPTH];
  logic [7:0]      loMem [WORD_DEPTH];

  always_ff @(posedge clk) begin
    if (strobe.wrHi) hiMem[wordAddr] <= cpuData[HI_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (strobe.wrLo) loMem[wordAddr] <= cpuData;
  end

  // Stage 2: palette read (old data on same-cycle write)
  logic [USED_W-1:0] palWord;

  always_ff @(posedge clk) begin
    if (rst)                  palWord <= '0;
    else if (strobe.loadWord) palWord <= {hiMem[wordIdx], loMem[wordIdx]};
  end

  // Stage 3: channel widening
  logic [3*OUT_W-1:0] rgbNext;

  for (genvar ch = 0; ch < 3; ch++) begin : g_chan
    logic [CH_W-1:0] field;
    assign field = palWord[ch*CH_W +: CH_W];
    assign rgbNext[(2-ch)*OUT_W +: OUT_W] = {field, field[CH_W-1 -: REP_W]};

    // R5
    replicate_bits_chk: assert property (@(posedge clk) disable iff (rst)
      rgb[(2-ch)*OUT_W +: REP_W] == rgb[(2-ch)*OUT_W + OUT_W - 1 -: REP_W]);
  end

  always_ff @(posedge clk) begin
    if (rst)                 rgb <= '0;
    else if (strobe.loadRgb) rgb <= rgbNext;
  end

  // R9
  hold_colour_chk: assert property (@(posedge clk) disable iff (rst)
    !strobe.loadRgb |=> $stable(rgb));

endmodule

// File: rtl/palette_expand.sv
module palette_expand
  import palexp_pkg::*;
#(
  parameter int IDX_W   = 14,
  parameter int PAGE_W  = 4,
  parameter int LOW_W   = 4,
  parameter int WORD_AW = 10,
  parameter int CH_W    = 5,
  parameter int OUT_W   = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    pixValid,
  input  logic [IDX_W-1:0]        pixIdx,
  input  logic                    cpuWe,
  input  logic [WORD_AW:0]        cpuAddr,
  input  logic [7:0]              cpuData,
  input  logic                    promWe,
  input  logic [PAGE_W+LOW_W-1:0] promAddr,
  input  logic [LOW_W-1:0]        promData,
  output logic                    rgbValid,
  output logic [3*OUT_W-1:0]      rgb
);

  palStrobe_t strobe;

  palexp_ctrl u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .pixValid   (pixValid),
    .cpuWe      (cpuWe),
    .cpuByteSel (cpuAddr[0]),
    .promWe     (promWe),
    .strobe     (strobe),
    .rgbValid   (rgbValid)
  );

  palexp_datapath #(
    .IDX_W   (IDX_W),
    .PAGE_W  (PAGE_W),
    .LOW_W   (LOW_W),
    .WORD_AW (WORD_AW),
    .CH_W    (CH_W),
    .OUT_W   (OUT_W)
  ) u_dp (
    .clk      (clk),
    .rst      (rst),
    .strobe   (strobe),
    .pixIdx   (pixIdx),
    .wordAddr (cpuAddr[WORD_AW:1]),
    .cpuData  (cpuData),
    .promAddr (promAddr),
    .promData (promData),
    .rgb      (rgb)
  );

endmodule

// File: tb/tb_palette_expand.sv
`timescale 1ns/1ps
module tb_palette_expand;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        pixValid = 1'b0;
  logic [13:0] pixIdx = '0;
  logic        cpuWe = 1'b0;
  logic [10:0] cpuAddr = '0;
  logic [7:0]  cpuData = '0;
  logic        promWe = 1'b0;
  logic [7:0]  promAddr = '0;
  logic [3:0]  promData = '0;
  logic        rgbValid;
  logic [23:0] rgb;

  always #10 clk = ~clk;

  palette_expand dut (
    .clk(clk), .rst(rst), .pixValid(pixValid), .pixIdx(pixIdx),
    .cpuWe(cpuWe), .cpuAddr(cpuAddr), .cpuData(cpuData),
    .promWe(promWe), .promAddr(promAddr), .promData(promData),
    .rgbValid(rgbValid), .rgb(rgb)
  );

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  logic [23:0] lastRgb = '0;

  logic [3:0] promM [256];
  logic [7:0] ramM  [2048];

  logic [23:0] qRgb[$];
  int          qCyc[$];
  string       qTag[$];

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [9:0] wordOf(logic [13:0] idx);
    return {idx[9:4], promM[{idx[13:10], idx[3:0]}]};
  endfunction

  function automatic logic [7:0] widen(logic [4:0] c);
    return {c, c[4:2]};
  endfunction

  function automatic logic [23:0] rgbOf(logic [13:0] idx);
    logic [9:0]  w;
    logic [15:0] word;
    w = wordOf(idx);
    word = {ramM[{w, 1'b0}], ramM[{w, 1'b1}]};
    return {widen(word[4:0]), widen(word[9:5]), widen(word[14:10])};
  endfunction

  task automatic report(string tag, logic [23:0] act, logic [23:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%06h expected=%06h", tag, act, exp);
    end
  endtask

  // Driver: one cycle with optional pixel and optional palette write
  task automatic doCycle(bit pv, logic [13:0] idx, bit we, logic [10:0] a,
                         logic [7:0] d, string tag);
    if (we) ramM[a] = d;
    if (pv) begin
      qRgb.push_back(rgbOf(idx));
      qCyc.push_back(cyc + 3);
      qTag.push_back(tag);
    end
    pixValid = pv; pixIdx = idx;
    cpuWe = we; cpuAddr = a; cpuData = d;
    @(negedge clk);
    pixValid = 1'b0; cpuWe = 1'b0;
  endtask

  task automatic promWrite(logic [7:0] a, logic [3:0] d);
    promM[a] = d;
    promWe = 1'b1; promAddr = a; promData = d;
    @(negedge clk);
    promWe = 1'b0;
  endtask

  // Monitor: pops the scoreboard as results appear
  always @(negedge clk) begin
    if (!rst && rgbValid) begin
      if (qRgb.size() == 0) begin
        checks++; errors++;
        $display("FAIL R1: actual=unexpected output %06h expected=no output", rgb);
      end else begin
        logic [23:0] e;
        int ec;
        string t;
        e = qRgb.pop_front(); ec = qCyc.pop_front(); t = qTag.pop_front();
        report(t, rgb, e);
        checks++;
        if (cyc != ec) begin
          errors++;
          $display("FAIL R1: actual=cycle %0d expected=cycle %0d", cyc, ec);
        end
      end
      lastRgb = rgb;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R8: reset state
    report("R8", {rgbValid, rgb}, 25'h0);
    rst = 1'b0;
    @(negedge clk);
    report("R8", {rgbValid, rgb}, 25'h0);

    for (int a = 0; a < 256; a++) promWrite(8'(a), 4'($urandom));
    for (int a = 0; a < 2048; a++) doCycle(0, '0, 1, 11'(a), 8'($urandom), "");

    // R3 R4 R5: word 5 = 0xC01F via table entry 3
    promWrite(8'h03, 4'h5);
    doCycle(0, '0, 1, 11'd10, 8'hC0, "");
    doCycle(0, '0, 1, 11'd11, 8'h1F, "");
    doCycle(1, 14'h0003, 0, '0, '0, "R3 R5");
    repeat (4) @(negedge clk);
    report("R5", lastRgb, 24'hFF0084);
    // R4: clearing bit 15 only leaves colour unchanged
    doCycle(0, '0, 1, 11'd10, 8'h40, "");
    doCycle(1, 14'h0003, 0, '0, '0, "R4");
    // saturated and empty words
    doCycle(0, '0, 1, 11'd10, 8'h7F, "");
    doCycle(0, '0, 1, 11'd11, 8'hFF, "");
    doCycle(1, 14'h0003, 0, '0, '0, "R4");
    doCycle(0, '0, 1, 11'd10, 8'h80, "");
    doCycle(0, '0, 1, 11'd11, 8'h00, "");
    doCycle(1, 14'h0003, 0, '0, '0, "R4");
    repeat (4) @(negedge clk);
    report("R4", lastRgb, 24'h000000);

    // R1 R2: back-to-back random stream
    for (int k = 0; k < 400; k++) doCycle(1, 14'($urandom), 0, '0, '0, "R2");
    // R1 R2: gapped stream
    for (int k = 0; k < 300; k++) doCycle(1'($urandom), 14'($urandom), 0, '0, '0, "R1");
    repeat (4) @(negedge clk);

    // R6: table reload seen by next pixel
    for (int k = 0; k < 20; k++) begin
      logic [13:0] idx;
      idx = 14'($urandom);
      promWrite({idx[13:10], idx[3:0]}, 4'($urandom));
      doCycle(1, idx, 0, '0, '0, "R6");
    end

    // R7: write after pixel is unseen; write with pixel is seen
    for (int k = 0; k < 20; k++) begin
      logic [13:0] idx;
      logic [9:0]  w;
      idx = 14'($urandom);
      w = wordOf(idx);
      doCycle(1, idx, 0, '0, '0, "R7");
      doCycle(0, '0, 1, {w, 1'b1}, 8'($urandom), "");
      doCycle(1, idx, 0, '0, '0, "R7");
      doCycle(1, idx, 1, {w, 1'b0}, 8'($urandom), "R7");
    end

    repeat (6) @(negedge clk);
    // R1: every pixel produced a result
    report("R1", 24'(qRgb.size()), 24'd0);
    // R9: colour holds while idle
    report("R9", {rgbValid, rgb}, {1'b0, lastRgb});
    repeat (5) @(negedge clk);
    report("R9", {rgbValid, rgb}, {1'b0, lastRgb});

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule